// File: doc/BRIEF.md
# Byte-Aligning Preamble Detector and Frame Synchronizer

This block sits behind a deserializer that delivers one byte per clock but whose byte boundary relative to the transmitted bit stream is unknown. It keeps a sliding window of the most recent received bits and runs eight correlators in parallel, one for each of the eight possible bit offsets. Each correlator counts how many of its 32 window bits agree with a fixed 32-bit preamble. A correlator whose count reaches the threshold reports a hit. When several correlators hit together, one winner is chosen.

Frames repeat every 260 bytes: 4 preamble bytes followed by 256 coded bytes. A first hit records the winning offset. The block then looks only at the single byte position where the next preamble must end, one frame length later. Lock is declared once the same offset has hit at three consecutive expected positions. While locked, a missed preamble is tolerated and the frame counter keeps running. Three consecutive misses drop the lock and restart the search.

The output is the input stream realigned to the locked bit offset. A one-cycle pulse marks the first byte after the preamble, and a level flag shows the lock state.

Top module: `preamble_frame_sync`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lock_o` and `sop_o` are 0 and `data_o` is 0x00.
- R2: Bits enter most significant bit first: bit 7 of `rx_byte_i` is the earliest bit of that byte. For offset k (0..7), the correlator compares the 32 bits that end k bit positions before the newest received bit against the preamble. The earliest of those bits pairs with preamble bit 31. The correlator's count is the number of equal bit pairs, and it hits when the count is at least the effective threshold.
- R3: The effective threshold is 28 when `thr_cfg_i` is 0, and `thr_cfg_i` otherwise. A preamble with 4 flipped bits (count 28) is accepted under the default, a preamble with 5 flipped bits (count 27) is not, and a preamble with 4 flipped bits is rejected when `thr_cfg_i` is 29.
- R4: When several correlators hit in the same cycle, the one with the highest count wins. Ties go to the lowest offset.
- R5: While searching, a winning hit records its offset. Lock is declared when the correlator at that offset hits at two further positions, each exactly 260 bytes after the previous one. `lock_o` rises one cycle after the third hit.
- R6: While confirming a candidate, a miss at the expected position discards the candidate and returns the block to searching.
- R7: While locked, only the correlator at the locked offset, at the expected position, is examined. One or two consecutive misses keep `lock_o` high, leave the frame counter running and still produce the payload pulse.
- R8: While locked, the third consecutive miss at the expected position clears `lock_o` one cycle later. Any hit resets the miss run.
- R9: `data_o` is the byte formed from the 8 bits that end k bit positions before the newest bit, where k is the held offset. The byte is presented two clock cycles after the byte that completes it entered, most significant bit first. Payload bytes leave in their transmitted order and value.
- R10: `sop_o` is a one-cycle pulse, given only while locked, in the cycle where `data_o` carries the first byte after the 4 preamble bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_i | input | 8 | Received byte from the deserializer, arbitrary bit alignment |
| thr_cfg_i | input | 6 | Detection threshold; 0 selects the default of 28 |
| data_o | output | 8 | Realigned byte stream |
| sop_o | output | 1 | Pulse marking the first payload byte of a frame |
| lock_o | output | 1 | Frame lock indicator |

## Verification
Two situations are hard to bring about from the ports. The first is a tie between correlators. The second is a candidate that hits once, misses once, and must then be dropped.

For the tie, the bench chooses a preamble with exactly 16 ones, feeds an all-zero stream and sets the threshold to 16. All eight correlators then report the same count every cycle, and the chosen offset shows up as an unshifted byte on `data_o`.

For the candidate case, whole frames are built bit by bit in a queue. Arbitrary filler bits set the offset, and per-frame counts of flipped preamble bits decide each expected position's outcome. This lets the bench script an exact hit/miss sequence one frame length apart, including single misses, loss and threshold edges.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    SYNC_HUNT    = 2'd0,
    SYNC_CONFIRM = 2'd1,
    SYNC_LOCK    = 2'd2
  } sync_state_e;

  // Effective threshold: a zero setting selects the built-in default.
  function automatic int unsigned resolve_thr(input int unsigned cfg, input int unsigned dflt);
    return (cfg == 0) ? dflt : cfg;
  endfunction

endpackage

// File: rtl/pfs_window.sv
module pfs_window #(
  parameter int WIN_BITS = 39
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          byte_i,
  output logic [WIN_BITS-1:0] win_o
);
  // Newest byte enters at the low end; older bits move up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_o <= '0;
    else        win_o <= {win_o[WIN_BITS-9:0], byte_i};
  end
endmodule

// File: rtl/pfs_corr_bank.sv
module pfs_corr_bank #(
  parameter int                PRE_BITS = 32,
  parameter int                OFFSETS  = 8,
  parameter logic [PRE_BITS-1:0] PREAMBLE = 32'hC5A396E1,
  localparam int WIN_BITS = PRE_BITS + OFFSETS - 1,
  localparam int CNT_W    = $clog2(PRE_BITS + 1),
  localparam int IDX_W    = $clog2(OFFSETS)
) (
  input  logic [WIN_BITS-1:0] win_i,
  input  logic [CNT_W-1:0]    thr_i,
  output logic [OFFSETS-1:0]  hit_o,
  output logic                win_valid_o,
  output logic [IDX_W-1:0]    win_idx_o
);
  logic [CNT_W-1:0] cnt [OFFSETS];

  // Number of bit positions where the segment equals the preamble.
  function automatic logic [CNT_W-1:0] agreement(input logic [PRE_BITS-1:0] seg);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < PRE_BITS; i++) acc = acc + CNT_W'(~(seg[i] ^ PREAMBLE[i]));
    return acc;
  endfunction

  for (genvar k = 0; k < OFFSETS; k++) begin : g_corr
    assign cnt[k]   = agreement(win_i[k +: PRE_BITS]);
    assign hit_o[k] = (cnt[k] >= thr_i);
  end

  // Highest count wins; strict compare keeps the lowest index on ties.
  always_comb begin
    logic [CNT_W-1:0] best;
    best        = '0;
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int k = 0; k < OFFSETS; k++) begin
      if (hit_o[k] && (!win_valid_o || cnt[k] > best)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(k);
        best        = cnt[k];
      end
    end
  end
endmodule

// File: rtl/pfs_tracker.sv
module pfs_tracker
  import pfs_pkg::*;
#(
  parameter int OFFSETS     = 8,
  parameter int FRAME_BYTES = 260,
  parameter int ACQ_HITS    = 3,
  parameter int LOSS_MISSES = 3,
  localparam int IDX_W  = $clog2(OFFSETS),
  localparam int POS_W  = $clog2(FRAME_BYTES),
  localparam int HIT_W  = $clog2(ACQ_HITS + 1),
  localparam int MISS_W = $clog2(LOSS_MISSES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFFSETS-1:0] hit_vec_i,
  input  logic               win_valid_i,
  input  logic [IDX_W-1:0]   win_idx_i,
  output logic [IDX_W-1:0]   off_o,
  output logic               locked_o,
  output logic               sop_next_o,
  output logic               chk_cycle_o,
  output logic               hit_at_off_o
);
  sync_state_e       state;
  logic [POS_W-1:0]  pos_q;
  logic [HIT_W-1:0]  hits_q;
  logic [MISS_W-1:0] miss_q;
  logic              last_pos;

  assign last_pos     = (pos_q == POS_W'(FRAME_BYTES - 1));
  assign chk_cycle_o  = (state != SYNC_HUNT) && last_pos;
  assign hit_at_off_o = hit_vec_i[off_o];
  assign locked_o     = (state == SYNC_LOCK);
  assign sop_next_o   = (state == SYNC_LOCK) && (pos_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SYNC_HUNT;
      off_o  <= '0;
      pos_q  <= '0;
      hits_q <= '0;
      miss_q <= '0;
    end else begin
      if (state != SYNC_HUNT) pos_q <= last_pos ? '0 : pos_q + POS_W'(1);
      unique case (state)
        SYNC_HUNT: begin
          if (win_valid_i) begin
            off_o  <= win_idx_i;
            pos_q  <= '0;
            hits_q <= HIT_W'(1);
            miss_q <= '0;
            state  <= (ACQ_HITS <= 1) ? SYNC_LOCK : SYNC_CONFIRM;
          end
        end
        SYNC_CONFIRM: begin
          if (chk_cycle_o) begin
            if (hit_at_off_o) begin
              hits_q <= hits_q + HIT_W'(1);
              if (hits_q == HIT_W'(ACQ_HITS - 1)) state <= SYNC_LOCK;
            end else begin
              state <= SYNC_HUNT;
            end
          end
        end
        SYNC_LOCK: begin
          if (chk_cycle_o) begin
            if (hit_at_off_o)                             miss_q <= '0;
            else if (miss_q == MISS_W'(LOSS_MISSES - 1))  state  <= SYNC_HUNT;
            else                                          miss_q <= miss_q + MISS_W'(1);
          end
        end
        default: state <= SYNC_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/pfs_realign.sv
module pfs_realign #(
  parameter int OFFSETS = 8,
  localparam int SEG_W = OFFSETS + 7,
  localparam int IDX_W = $clog2(OFFSETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [IDX_W-1:0] off_i,
  input  logic             sop_next_i,
  output logic [7:0]       data_o,
  output logic             sop_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      sop_o  <= 1'b0;
    end else begin
      data_o <= seg_i[off_i +: 8];
      sop_o  <= sop_next_i;
    end
  end
endmodule

// File: rtl/preamble_frame_sync.sv
module preamble_frame_sync
  import pfs_pkg::*;
#(
  parameter int                  PRE_BITS    = 32,
  parameter int                  OFFSETS     = 8,
  parameter logic [PRE_BITS-1:0] PREAMBLE    = 32'hC5A396E1,
  parameter int                  FRAME_BYTES = 260,
  parameter int                  ACQ_HITS    = 3,
  parameter int                  LOSS_MISSES = 3,
  parameter int                  DEF_THR     = 28,
  localparam int CNT_W    = $clog2(PRE_BITS + 1),
  localparam int IDX_W    = $clog2(OFFSETS),
  localparam int WIN_BITS = PRE_BITS + OFFSETS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_byte_i,
  input  logic [CNT_W-1:0] thr_cfg_i,
  output logic [7:0]       data_o,
  output logic             sop_o,
  output logic             lock_o
);
  logic [WIN_BITS-1:0] win;
  logic [CNT_W-1:0]    eff_thr;
  logic [OFFSETS-1:0]  hit_vec;
  logic                win_valid;
  logic [IDX_W-1:0]    win_idx;
  logic [IDX_W-1:0]    off_q;
  logic                sop_next;
  logic                chk_cycle;
  logic                hit_at_off;

  assign eff_thr = CNT_W'(resolve_thr(int'(thr_cfg_i), DEF_THR));

  pfs_window #(.WIN_BITS(WIN_BITS)) u_win (
    .clk(clk), .rst_n(rst_n), .byte_i(rx_byte_i), .win_o(win)
  );

  pfs_corr_bank #(.PRE_BITS(PRE_BITS), .OFFSETS(OFFSETS), .PREAMBLE(PREAMBLE)) u_bank (
    .win_i(win), .thr_i(eff_thr), .hit_o(hit_vec),
    .win_valid_o(win_valid), .win_idx_o(win_idx)
  );

  pfs_tracker #(.OFFSETS(OFFSETS), .FRAME_BYTES(FRAME_BYTES),
                .ACQ_HITS(ACQ_HITS), .LOSS_MISSES(LOSS_MISSES)) u_trk (
    .clk(clk), .rst_n(rst_n), .hit_vec_i(hit_vec), .win_valid_i(win_valid),
    .win_idx_i(win_idx), .off_o(off_q), .locked_o(lock_o), .sop_next_o(sop_next),
    .chk_cycle_o(chk_cycle), .hit_at_off_o(hit_at_off)
  );

  pfs_realign #(.OFFSETS(OFFSETS)) u_out (
    .clk(clk), .rst_n(rst_n), .seg_i(win[OFFSETS+6:0]), .off_i(off_q),
    .sop_next_i(sop_next), .data_o(data_o), .sop_o(sop_o)
  );
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int OFFSETS = 8,
  localparam int IDX_W = $clog2(OFFSETS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lock_o,
  input logic               sop_o,
  input logic               chk_cycle,
  input logic               hit_at_off,
  input logic [OFFSETS-1:0] hit_vec,
  input logic               win_valid,
  input logic [IDX_W-1:0]   win_idx,
  input logic [IDX_W-1:0]   off_q
);
  assert_winner_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> hit_vec[win_idx]);

  assert_lock_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(chk_cycle && hit_at_off));

  assert_lock_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(chk_cycle && !hit_at_off));

  assert_offset_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !chk_cycle) |=> $stable(off_q));

  assert_sop_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |-> lock_o);

  assert_sop_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |=> !sop_o);
endmodule

bind preamble_frame_sync pfs_checker #(.OFFSETS(OFFSETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_o(lock_o), .sop_o(sop_o),
  .chk_cycle(chk_cycle), .hit_at_off(hit_at_off), .hit_vec(hit_vec),
  .win_valid(win_valid), .win_idx(win_idx), .off_q(off_q)
);

// File: tb/sim_preamble_frame_sync.sv
module sim_preamble_frame_sync;
  localparam logic [31:0] PRE = 32'hC5A396E1;
  localparam int FRAME = 260;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [5:0] thr_cfg = 6'd0;
  wire  [7:0] data_o;
  wire        sop_o, lock_o;

  preamble_frame_sync #(.PREAMBLE(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_byte_i(rx_byte), .thr_cfg_i(thr_cfg),
    .data_o(data_o), .sop_o(sop_o), .lock_o(lock_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit started = 0, done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit         mw[$];
  int         m_state, m_off, m_pos, m_hits, m_miss;
  logic [7:0] e_data;
  bit         e_sop;
  int         thr_m, best, bidx, c;
  bit         hit_off;

  function automatic int agree(input int k);
    int a = 0;
    for (int i = 0; i < 32; i++) if (mw[39-k-i] == PRE[i]) a++;
    return a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mw = {};
      repeat (40) mw.push_back(1'b0);
      m_state = 0; m_off = 0; m_pos = 0; m_hits = 0; m_miss = 0;
      e_data = 8'h00; e_sop = 0;
    end else begin
      thr_m = (thr_cfg == 0) ? 28 : int'(thr_cfg);
      for (int i = 0; i < 8; i++) e_data[i] = mw[39-m_off-i];
      e_sop = (m_state == 2) && (m_pos == 0);
      best = -1; bidx = -1;
      for (int k = 0; k < 8; k++) begin
        c = agree(k);
        if (c >= thr_m && c > best) begin best = c; bidx = k; end
      end
      hit_off = agree(m_off) >= thr_m;
      if (m_state == 0) begin
        if (bidx >= 0) begin
          m_off = bidx; m_hits = 1; m_miss = 0; m_pos = 0; m_state = 1;
        end
      end else if (m_pos == FRAME-1) begin
        m_pos = 0;
        if (m_state == 1) begin
          if (hit_off) begin m_hits++; if (m_hits == 3) m_state = 2; end
          else m_state = 0;
        end else begin
          if (hit_off) m_miss = 0;
          else begin m_miss++; if (m_miss == 3) m_state = 0; end
        end
      end else begin
        m_pos++;
      end
      for (int i = 7; i >= 0; i--) mw.push_back(rx_byte[i]);
      repeat (8) void'(mw.pop_front());
    end
  end

  // ---------------- per-cycle comparison and observers ----------------
  int  sop_cnt = 0, fall_cnt = 0, cap_idx = 0, cap_bad = 0, cap_frames = 0;
  bit  cap_on = 0, cap_en = 1, prev_lock = 0;

  always @(negedge clk) begin
    if (rst_n && started) begin
      check(data_o == e_data, "R2/R9 data_o vs model", data_o, e_data);
      check(sop_o == e_sop, "R10 sop_o vs model", sop_o, e_sop);
      check(lock_o == (m_state == 2), "R5/R8 lock_o vs model", lock_o, m_state == 2);
      if (sop_o) begin sop_cnt++; cap_on = cap_en; cap_idx = 0; end
      if (cap_on) begin
        if (data_o != (cap_idx[7:0] ^ 8'h5A)) cap_bad++;
        cap_idx++;
        if (cap_idx == 256) begin cap_on = 0; cap_frames++; end
      end
      if (prev_lock && !lock_o) fall_cnt++;
      prev_lock = lock_o;
    end
  end

  // ---------------- stimulus ----------------
  bit      txq[$];
  int unsigned seed = 32'h1234_5678;

  task automatic push_bits(input logic [31:0] w, input int n);
    for (int i = n-1; i >= 0; i--) txq.push_back(w[i]);
  endtask

  task automatic push_frame(input int errs);
    push_bits(PRE ^ ((32'h1 << errs) - 32'h1), 32);
    for (int i = 0; i < 256; i++) push_bits(32'(i[7:0] ^ 8'h5A), 8);
  endtask

  task automatic drain();
    while (txq.size() >= 8) begin
      logic [7:0] b;
      @(negedge clk);
      for (int i = 7; i >= 0; i--) b[i] = txq.pop_front();
      rx_byte = b;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    // R1 reset state
    check(lock_o == 0, "R1 lock after reset", lock_o, 0);
    check(sop_o == 0, "R1 sop after reset", sop_o, 0);
    check(data_o == 8'h00, "R1 data after reset", data_o, 0);

    // R5: acquisition at a 3-bit shift, default threshold
    push_bits(32'h5, 3);
    repeat (4) push_frame(0);
    drain();
    check(lock_o == 1, "R5 locked after three hits", lock_o, 1);
    check(sop_cnt == 2, "R10 payload pulses after lock", sop_cnt, 2);

    // R7: single miss keeps lock and the frame count
    sop_cnt = 0; fall_cnt = 0;
    push_frame(8); push_frame(0); push_frame(0);
    drain();
    check(lock_o == 1 && fall_cnt == 0, "R7 lock kept over one miss", fall_cnt, 0);
    check(sop_cnt == 3, "R7 pulse on missed frame too", sop_cnt, 3);

    // R8: two misses keep lock, third drops it
    push_frame(8); push_frame(8);
    drain();
    check(lock_o == 1, "R8 lock after two misses", lock_o, 1);
    push_frame(8);
    drain();
    check(lock_o == 0, "R8 lock lost after third miss", lock_o, 0);

    // R3: default threshold accepts 28, rejects 27; 29 rejects 28
    push_bits(32'h1F, 5);
    repeat (4) push_frame(4);
    drain();
    check(lock_o == 1, "R3 default threshold accepts count 28", lock_o, 1);
    repeat (3) push_frame(5);
    drain();
    check(lock_o == 0, "R3 count 27 below default", lock_o, 0);
    thr_cfg = 6'd29;
    repeat (4) push_frame(4);
    drain();
    check(lock_o == 0, "R3 threshold 29 rejects count 28", lock_o, 0);
    thr_cfg = 6'd28;
    repeat (4) push_frame(4);
    drain();
    check(lock_o == 1, "R3 explicit threshold 28", lock_o, 1);

    // R6: candidate dropped on a miss during confirmation
    repeat (3) push_frame(8);
    push_frame(0); push_frame(8); push_frame(0); push_frame(0);
    drain();
    check(lock_o == 0, "R6 candidate discarded after miss", lock_o, 0);
    push_frame(0);
    drain();
    check(lock_o == 1, "R6 relock after fresh three hits", lock_o, 1);
    check(cap_frames > 0 && cap_bad == 0, "R9 realigned payload bytes", cap_bad, 0);

    // R2/R4: random stream with a low threshold, compared to the model only
    cap_en = 0; cap_on = 0;
    thr_cfg = 6'd20;
    repeat (2000) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      push_bits(32'(seed[23:16]), 8);
    end
    drain();

    // R4: tie on an all-zero stream picks offset 0
    txq.delete();
    thr_cfg = 6'd40;
    repeat (3*FRAME + 8) push_bits(32'h0, 8);
    drain();
    check(lock_o == 0, "R4 search forced before tie test", lock_o, 0);
    thr_cfg = 6'd16;
    repeat (3*FRAME + 8) push_bits(32'h0, 8);
    drain();
    check(lock_o == 1, "R4 lock on tied counts", lock_o, 1);
    push_bits(32'h3C, 8); drain();
    push_bits(32'h00, 8); drain();
    push_bits(32'h00, 8); drain();
    check(data_o == 8'h3C, "R4 tie resolved to lowest offset", data_o, 8'h3C);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule